// File: doc/BRIEF.md
# Sequential-Address Sideband Bus Codec

This block is an encoder and decoder pair for a processor-to-memory address bus. The encoder adds one sideband line to the address lines. A low level on that line means the new address is the previous real address plus a fixed stride. In that case the encoder leaves the address lines exactly as they were, so a run of consecutive fetches causes no switching on them. Any other address goes out as plain binary, with the sideband line high.

The decoder keeps its own copy of the last real address. When the sideband line is low, it adds the stride to that copy. When the line is high, it takes the bus value as it stands. The top module chains the encoder to the decoder and brings out the encoded bus, so the bus traffic can be observed. The encoder adds one registered cycle and the decoder adds one more. The address width and the stride are parameters, and the increment wraps modulo two to the power of the width. Both sides use a synchronous active-low reset.

Top module: `t0_codec`

## Requirements
- R1: When `src_valid` is 1 and `src_addr` equals the encoder's last real address plus `STRIDE` (modulo 2^`ADDR_W`), `bus_seq_n` is driven to 0 in the next cycle. For any other valid address it is driven to 1.
- R2: The first valid address after reset is always sent out of sequence: `bus_seq_n` = 1 and `bus_addr` holds the full address. This holds even if the address happens to equal the reset value plus the stride.
- R3: On an in-sequence transfer, `bus_addr` keeps its previous value. A run of consecutive addresses therefore causes zero toggles on the address lines.
- R4: On an out-of-sequence transfer, `bus_addr` carries `src_addr` in plain binary one cycle after the input.
- R5: In a cycle with `src_valid` = 0, the next cycle has `bus_valid` = 0 and `bus_addr` and `bus_seq_n` unchanged. Neither side changes its stored last address, so an address that follows idle cycles is still tested against the last real address.
- R6: Each valid input appears on `bus_valid` one cycle later. It appears on `dst_valid` with `dst_addr` equal to the input address two cycles later.
- R7: The increment wraps: with `STRIDE` = 1, address 0 after the all-ones address counts as in sequence.
- R8: After reset, `bus_valid` = 0, `bus_addr` = 0, `bus_seq_n` = 1, `dst_valid` = 0 and `dst_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source address strobe |
| src_addr | input | ADDR_W | Source address |
| bus_valid | output | 1 | Encoded bus strobe |
| bus_addr | output | ADDR_W | Encoded address lines |
| bus_seq_n | output | 1 | Sideband line: 0 means in sequence, 1 means full address |
| dst_valid | output | 1 | Decoded address strobe |
| dst_addr | output | ADDR_W | Decoded address |

## Verification
On every cycle, the assertions check the following:
- the address lines stay frozen on in-sequence and idle cycles;
- the first transfer after reset is flagged out of sequence;
- the end-to-end path returns each source address two cycles later.

Only the bench scenarios can show the following:
- the sideband decision is correct against an independent model, across random mixes of runs, jumps and gaps;
- the modulo wrap at the all-ones address;
- a reset in the middle of a run;
- the measured count of zero toggles over a long consecutive run.

// File: rtl/t0_pkg.sv
// Shared definitions for the sequential-address sideband codec.
// Assumes: the sideband line is active-low for "in sequence".
package t0_pkg;
    typedef enum logic {
        SEQ_IN  = 1'b0,
        SEQ_OUT = 1'b1
    } seq_flag_e;
endpackage

// File: rtl/t0_encoder.sv
// Encoder: compares each valid address with the last real address plus
// STRIDE. In sequence, it freezes the address lines and drives the sideband
// low. Otherwise, it drives the binary address with the sideband high.
// Assumes: outputs are registered, one cycle of latency, no back-pressure.
module t0_encoder
    import t0_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              enc_valid,
    output logic [ADDR_W-1:0] enc_addr,
    output logic              enc_flag
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] last_q;
    logic              primed_q;
    logic              in_seq;

    // Sequence test against the stored address; never true before the first transfer.
    always_comb in_seq = primed_q && (in_addr == last_q + STEP);

    // Register the bus and update the history, on valid transfers only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= '0;
            primed_q  <= 1'b0;
            enc_valid <= 1'b0;
            enc_addr  <= '0;
            enc_flag  <= SEQ_OUT;
        end else begin
            enc_valid <= in_valid;
            if (in_valid) begin
                last_q   <= in_addr;
                primed_q <= 1'b1;
                enc_flag <= in_seq ? SEQ_IN : SEQ_OUT;
                if (!in_seq) enc_addr <= in_addr;
            end
        end
    end

    // R2: the first transfer after reset is flagged out of sequence.
    a_r2_first_full: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) && !$past(primed_q) |-> enc_flag == SEQ_OUT && enc_addr == $past(in_addr));

    // R3: an in-sequence transfer leaves the address lines untouched.
    a_r3_freeze_lines: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && enc_valid && enc_flag == SEQ_IN |-> $stable(enc_addr));

    // R5: idle cycles change nothing on the bus.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !enc_valid |-> $stable(enc_addr) && $stable(enc_flag));
endmodule

// File: rtl/t0_decoder.sv
// Decoder: rebuilds the address from the encoded bus. With the sideband low,
// it adds STRIDE to the last real address; otherwise it takes the bus value.
// Assumes: the encoder flags the first transfer after a common reset as full.
module t0_decoder
    import t0_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [ADDR_W-1:0] enc_addr,
    input  logic              enc_flag,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] rebuilt;

    // Choose between the predicted successor and the bus value.
    always_comb rebuilt = (enc_flag == SEQ_IN) ? last_q + STEP : enc_addr;

    // Register the decoded address and keep it as the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= enc_valid;
            if (enc_valid) begin
                last_q   <= rebuilt;
                out_addr <= rebuilt;
            end
        end
    end

    // R5: the decoded output holds between transfers.
    a_r5_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !out_valid |-> $stable(out_addr));
endmodule

// File: rtl/t0_codec.sv
// Top: encoder chained to decoder, with the encoded bus brought out.
// Assumes: a single clock and reset for both sides.
module t0_codec #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [ADDR_W-1:0] src_addr,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_seq_n,
    output logic              dst_valid,
    output logic [ADDR_W-1:0] dst_addr
);
    t0_encoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(src_valid), .in_addr(src_addr),
        .enc_valid(bus_valid), .enc_addr(bus_addr), .enc_flag(bus_seq_n)
    );

    t0_decoder #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .clk(clk), .rst_n(rst_n), .enc_valid(bus_valid), .enc_addr(bus_addr),
        .enc_flag(bus_seq_n), .out_valid(dst_valid), .out_addr(dst_addr)
    );

    // R6: the strobe passes through the encoder in one cycle.
    a_r6_bus_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> bus_valid == $past(src_valid));

    // R6: end to end, the decoded address equals the source address two cycles earlier.
    a_r6_round_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_valid) |-> dst_valid && dst_addr == $past(src_addr, 2));
endmodule

// File: tb/t0_codec_test.sv
module t0_codec_test;
    localparam int ADDR_W = 32;
    localparam int STRIDE = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic [ADDR_W-1:0] src_addr = '0;
    logic              bus_valid, bus_seq_n, dst_valid;
    logic [ADDR_W-1:0] bus_addr, dst_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    logic [ADDR_W-1:0] m_last = '0;
    bit                m_have = 0;
    logic [ADDR_W-1:0] m_bus  = '0;
    logic              m_seq_n = 1'b1;
    bit                pd_v = 0;
    logic [ADDR_W-1:0] pd_a = '0;
    int                toggles = 0;

    t0_codec #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) uut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_addr(src_addr),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_seq_n(bus_seq_n),
        .dst_valid(dst_valid), .dst_addr(dst_addr)
    );

    always #4 clk = ~clk;

    function automatic bit succ(input logic [ADDR_W-1:0] prev, input logic [ADDR_W-1:0] a);
        return a == prev + ADDR_W'(STRIDE);
    endfunction

    task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, then check at the next falling edge.
    task automatic step(input bit v, input logic [ADDR_W-1:0] a, input string req);
        logic [ADDR_W-1:0] prev_bus;
        bit ins;
        prev_bus  = bus_addr;
        src_valid = v;
        src_addr  = a;
        if (v) begin
            ins = m_have && succ(m_last, a);
            m_seq_n = ins ? 1'b0 : 1'b1;
            if (!ins) m_bus = a;
            m_last = a;
            m_have = 1;
        end
        @(negedge clk);
        check(bus_valid == v, {req, " bus_valid"}, ADDR_W'(bus_valid), ADDR_W'(v));
        check(bus_seq_n == m_seq_n, {req, " bus_seq_n"}, ADDR_W'(bus_seq_n), ADDR_W'(m_seq_n));
        check(bus_addr == m_bus, {req, " bus_addr"}, bus_addr, m_bus);
        check(dst_valid == pd_v, "R6 dst_valid", ADDR_W'(dst_valid), ADDR_W'(pd_v));
        if (pd_v) check(dst_addr == pd_a, "R6 dst_addr", dst_addr, pd_a);
        toggles += $countones(bus_addr ^ prev_bus);
        pd_v = v;
        if (v) pd_a = a;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R8: reset state
        check(bus_valid == 1'b0, "R8 bus_valid", ADDR_W'(bus_valid), '0);
        check(bus_addr == '0, "R8 bus_addr", bus_addr, '0);
        check(bus_seq_n == 1'b1, "R8 bus_seq_n", ADDR_W'(bus_seq_n), 1);
        check(dst_valid == 1'b0, "R8 dst_valid", ADDR_W'(dst_valid), '0);
        check(dst_addr == '0, "R8 dst_addr", dst_addr, '0);
        m_last = '0; m_have = 0; m_bus = '0; m_seq_n = 1'b1; pd_v = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        logic [ADDR_W-1:0] a;
        int r;
        void'($urandom(32'd20240917));
        do_reset();
        // R2: the first address equals reset value plus stride, but must still go out full.
        step(1, ADDR_W'(STRIDE), "R2");
        check(bus_seq_n == 1'b1, "R2 first flagged full", ADDR_W'(bus_seq_n), 1);
        // R3: a run of consecutive addresses causes zero toggles.
        step(1, 32'h1000, "R4");
        toggles = 0;
        for (int i = 1; i <= 16; i++) step(1, 32'h1000 + i, "R3");
        check(toggles == 0, "R3 toggle count", ADDR_W'(toggles), '0);
        check(bus_seq_n == 1'b0, "R1 in-seq flag", ADDR_W'(bus_seq_n), '0);
        // R5: idle gaps keep the history, so the next successor is still in sequence.
        step(0, 32'hDEAD_BEEF, "R5");
        step(0, 32'h0, "R5");
        step(1, 32'h1011, "R5");
        check(bus_seq_n == 1'b0, "R5 gap then successor", ADDR_W'(bus_seq_n), '0);
        // R1: a repeated address is not in sequence.
        step(1, 32'h1011, "R1");
        // R4: a jump goes out in plain binary.
        step(1, 32'h0000_0040, "R4");
        // R7: wrap at the all-ones address.
        step(1, 32'hFFFF_FFFF, "R7");
        step(1, 32'h0000_0000, "R7");
        check(bus_seq_n == 1'b0 && bus_addr == 32'hFFFF_FFFF, "R7 wrap in sequence", bus_addr, 32'hFFFF_FFFF);
        step(0, '0, "R6");
        step(0, '0, "R6");
        // R2: reset mid-run, then the successor of the old address goes out full.
        do_reset();
        step(1, 32'h0000_0001, "R2");
        check(bus_seq_n == 1'b1 && bus_addr == 32'h1, "R2 after reset", bus_addr, 32'h1);
        // Random mix of runs, jumps and idle cycles.
        a = 32'h1;
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom_range(0, 9));
            if (r < 5) begin
                a = a + ADDR_W'(STRIDE);
                step(1, a, "R1");
            end else if (r < 7) begin
                step(0, $urandom(), "R5");
            end else begin
                a = $urandom();
                step(1, a, "R4");
            end
        end
        step(0, '0, "R6");
        step(0, '0, "R6");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule